// File: doc/BRIEF.md
# Gated Intermediate-Frequency Counter

This block measures the frequency of an external signal by counting its rising edges over a known time window. The window is built from a 1 kHz reference tick that arrives on a port. Software first programs a mode word, which holds the window length, the counting mode and the input choice. It then writes a control word that can clear the count and can start a measurement. A busy flag rises as soon as the start is accepted. The window itself opens only on the next reference tick, and it closes on its own after the programmed number of ticks. An extra window setting keeps the gate open with no limit. That window opens at once, and it ends only when software writes a finite window length.

There are two counting modes. In the halved mode only the first input is used, and every second rising edge is counted, so the frequency in kHz is twice the count divided by the window in ms. In the direct mode either input can be chosen, and every rising edge is counted. Both inputs pass through a synchronizer and an edge detector before they reach the counter. The count stops at all-ones instead of wrapping, and it holds its value after the window closes.

Top module: `gated_freq_counter`

## Requirements
- R1: After reset the count is 0, busy is 0, the mode word reads 0, and the gate is closed.
- R2: A write to address 1 with bit 0 set clears the count to 0 and resets the halving prescaler, so the first edge after a clear is never counted in halved mode.
- R3: A write to address 1 with bit 1 set, while idle, raises busy on the accepting clock edge. With a finite window, edges that occur before the next reference tick are not counted.
- R4: The mode word at address 0 has these fields: bits [2:0] hold the window code, bit 3 holds the mode (0 = halved, 1 = direct), and bit 4 holds the input choice (0 = first input, 1 = second input). Window codes 0, 1, 2 and 3 give 1, 4, 8 and 16 ticks. The gate opens on the first tick after the start and closes on the tick that ends that count. Busy falls on that same edge.
- R5: Window codes 4 to 7 mean an unlimited window. The gate opens on the start edge with no tick needed and stays open across any number of ticks. A mode-word write whose bit 2 is 0 closes the gate and clears busy on that write's edge. This write changes only the window field.
- R6: In halved mode the first input is counted no matter what bit 4 holds, and only every second rising edge increments the count.
- R7: In direct mode, the input picked by bit 4 is counted on every rising edge, and the other input is ignored.
- R8: The count changes only while the gate is open or on a clear. After the gate closes it holds, whatever the inputs do.
- R9: The count saturates at all-ones.
- R10: While busy, a mode-word write is ignored, except in the case of R5, and so is a start. The running measurement keeps its length and its mode.
- R11: A read of address 2 returns busy in bit 0, address 3 returns the count, and address 0 returns the mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fmIn | input | 1 | First measured input, asynchronous |
| amIn | input | 1 | Second measured input, asynchronous |
| refTick | input | 1 | One-cycle pulse at each rising edge of the 1 kHz reference |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | CNT_W | Read data for regAddr, combinational |
| busy | output | 1 | Measurement in progress (gate-judge flag) |
| countValue | output | CNT_W | Current count |

## Verification
Writes and ticks take effect on the clock edge that samples them. Busy and the mode readback are therefore checked at the falling edge right after that edge. A rising edge on an input reaches the count three clock edges after the pin changes: two synchronizer stages plus the counting register. For that reason every burst of pulses is followed by at least six idle cycles before the count is compared, and the last pulse of each window ends at least that long before the closing tick. The bench sweeps every finite window length, both modes, both input choices and several pulse densities, and it computes each expected count as pulses times ticks, halved and then saturated.

// File: rtl/gfc_pkg.sv
package gfc_pkg;

  // strobes and levels that the control side hands to the datapath
  typedef struct packed {
    logic clrCnt;
    logic gateOpen;
    logic modeDirect;
    logic pinSecond;
  } gfcCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_GATE  = 2'd2
  } gfcState_t;

  localparam int TICK_W = 5;

  // finite window codes map to tick counts; bit 2 of the code means unlimited
  function automatic logic [TICK_W-1:0] windowTicks(input logic [1:0] code);
    logic [TICK_W-1:0] t;
    case (code)
      2'd0:    t = 5'd1;
      2'd1:    t = 5'd4;
      2'd2:    t = 5'd8;
      default: t = 5'd16;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/gfc_ctrl.sv
module gfc_ctrl
  import gfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output gfcCtrl_t   ctrlOut,
  output logic       busy,
  output logic [4:0] modeWord
);

  gfcState_t         state;
  logic [2:0]        winCode;
  logic              modeDirect;
  logic              pinSecond;
  logic [TICK_W-1:0] ticksLeft;

  logic writeMode, writeCtrl, startReq, clrReq, unlimited, finiteWrite;

  assign writeMode   = regWe && (regAddr == 2'd0);
  assign writeCtrl   = regWe && (regAddr == 2'd1);
  assign startReq    = writeCtrl && regWdata[1];
  assign clrReq      = writeCtrl && regWdata[0];
  assign unlimited   = winCode[2];
  assign finiteWrite = writeMode && !regWdata[2];

  // mode word: fully writable when idle, window field only to end an unlimited gate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCode    <= '0;
      modeDirect <= 1'b0;
      pinSecond  <= 1'b0;
    end else if (writeMode && state == ST_IDLE) begin
      winCode    <= regWdata[2:0];
      modeDirect <= regWdata[3];
      pinSecond  <= regWdata[4];
    end else if (finiteWrite && state == ST_GATE && unlimited) begin
      winCode    <= regWdata[2:0];
    end
  end

  // gate sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ticksLeft <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state <= unlimited ? ST_GATE : ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (refTick) begin
            state     <= ST_GATE;
            ticksLeft <= windowTicks(winCode[1:0]);
          end
        end
        ST_GATE: begin
          if (unlimited) begin
            if (finiteWrite) state <= ST_IDLE;
          end else if (refTick) begin
            if (ticksLeft == 5'd1) state <= ST_IDLE;
            ticksLeft <= ticksLeft - 5'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy             = (state != ST_IDLE);
  assign ctrlOut.clrCnt   = clrReq;
  assign ctrlOut.gateOpen = (state == ST_GATE);
  assign ctrlOut.modeDirect = modeDirect;
  assign ctrlOut.pinSecond  = pinSecond;
  assign modeWord         = {pinSecond, modeDirect, winCode};

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);

  // R3
  gate_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut.gateOpen && !$past(ctrlOut.gateOpen) && !$past(unlimited)) |-> $past(refTick));

  // R4
  gate_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut.gateOpen && !unlimited && refTick && ticksLeft == 5'd1) |=> (!busy && !ctrlOut.gateOpen));

  // R5
  open_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut.gateOpen && unlimited && !writeMode) |=> ctrlOut.gateOpen);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(modeWord[4:3]));

endmodule

// File: rtl/gfc_datapath.sv
module gfc_datapath
  import gfc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  gfcCtrl_t         ctrlIn,
  input  logic             fmIn,
  input  logic             amIn,
  output logic [CNT_W-1:0] countOut
);

  localparam int                NUM_IN  = 2;
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] riseEdge;

  assign rawIn = {amIn, fmIn};

  // synchronizer and rising-edge detector per input
  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
    logic [SYNC_STAGES-1:0] syncChain;
    logic                   lastLevel;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncChain <= '0;
        lastLevel <= 1'b0;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn[gi]};
        lastLevel <= syncChain[SYNC_STAGES-1];
      end
    end
    assign riseEdge[gi] = syncChain[SYNC_STAGES-1] && !lastLevel;
  end

  logic selEdge;
  logic halfPhase;
  logic countHit;
  logic [CNT_W-1:0] cnt;

  assign selEdge  = (ctrlIn.modeDirect && ctrlIn.pinSecond) ? riseEdge[1] : riseEdge[0];
  assign countHit = ctrlIn.gateOpen && selEdge && (ctrlIn.modeDirect || halfPhase);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      halfPhase <= 1'b0;
    end else if (ctrlIn.clrCnt) begin
      cnt       <= '0;
      halfPhase <= 1'b0;
    end else begin
      if (ctrlIn.gateOpen && selEdge && !ctrlIn.modeDirect) halfPhase <= !halfPhase;
      if (countHit && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  assign countOut = cnt;

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.clrCnt |=> (countOut == '0));

  // R8
  closed_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlIn.gateOpen && !ctrlIn.clrCnt) |=> $stable(countOut));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countOut == CNT_MAX && !ctrlIn.clrCnt) |=> (countOut == CNT_MAX));

  // R6
  first_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlIn.modeDirect && !halfPhase && !ctrlIn.clrCnt) |=> $stable(countOut));

endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter
  import gfc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fmIn,
  input  logic             amIn,
  input  logic             refTick,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWdata,
  output logic [CNT_W-1:0] regRdata,
  output logic             busy,
  output logic [CNT_W-1:0] countValue
);

  gfcCtrl_t   ctrlBus;
  logic [4:0] modeWord;
  logic       busyInt;

  gfc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .refTick  (refTick),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .ctrlOut  (ctrlBus),
    .busy     (busyInt),
    .modeWord (modeWord)
  );

  gfc_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlIn   (ctrlBus),
    .fmIn     (fmIn),
    .amIn     (amIn),
    .countOut (countValue)
  );

  always_comb begin
    regRdata = '0;
    case (regAddr)
      2'd0:    regRdata[4:0] = modeWord;
      2'd2:    regRdata[0]   = busyInt;
      2'd3:    regRdata      = countValue;
      default: regRdata      = '0;
    endcase
  end

  assign busy = busyInt;

  // R11
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2) |-> (regRdata[0] == busy));

endmodule

// File: tb/gated_freq_counter_tb_top.sv
module gated_freq_counter_tb_top;

  localparam int CW  = 6;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fmIn = 1'b0, amIn = 1'b0, refTick = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [CW-1:0] regRdata, countValue;
  logic busy;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gated_freq_counter #(.CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .fmIn(fmIn), .amIn(amIn), .refTick(refTick),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .busy(busy), .countValue(countValue)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    regAddr = a;
    #1;
    v = int'(regRdata);
  endtask

  task automatic tick();
    @(negedge clk); refTick = 1'b1;
    @(negedge clk); refTick = 1'b0;
  endtask

  task automatic pulse(input bit second);
    @(negedge clk);
    if (second) amIn = 1'b1; else fmIn = 1'b1;
    idle(2);
    if (second) amIn = 1'b0; else fmIn = 1'b0;
    idle(2);
  endtask

  // one finite measurement; gcode 0..3, direct/pin as in the mode word
  task automatic measure(input int gcode, input bit direct, input bit pin, input int perMs);
    int ticksN, raw, expv, v;
    bit selSecond;
    ticksN = (gcode == 0) ? 1 : (gcode == 1) ? 4 : (gcode == 2) ? 8 : 16;
    selSecond = direct && pin;
    wr(2'd0, {3'b000, pin, direct, gcode[2:0]});
    wr(2'd1, 8'h01);
    chk("R2 clear", int'(countValue), 0);
    wr(2'd1, 8'h02);
    chk("R3 busy at start", int'(busy), 1);
    rd(2'd2, v);
    chk("R11 judge read", v, 1);
    pulse(selSecond); pulse(selSecond); idle(6);
    chk("R3 no count before tick", int'(countValue), 0);
    for (int k = 0; k < ticksN; k++) begin
      tick();
      for (int p = 0; p < perMs; p++) pulse(selSecond);
      pulse(!selSecond);
      idle(6);
    end
    chk("R4 busy before closing tick", int'(busy), 1);
    tick();
    chk("R4 busy after closing tick", int'(busy), 0);
    raw = ticksN * perMs;
    expv = direct ? raw : raw / 2;
    if (expv > MAXV) expv = MAXV;
    chk(direct ? "R7 R9 direct count" : "R6 R9 halved count", int'(countValue), expv);
    pulse(1'b0); pulse(1'b1); idle(6);
    chk("R8 hold after close", int'(countValue), expv);
    rd(2'd3, v);
    chk("R11 count read", v, expv);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    int v, expv;
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1
    chk("R1 count", int'(countValue), 0);
    chk("R1 busy", int'(busy), 0);
    rd(2'd0, v);
    chk("R1 mode word", v, 0);
    pulse(1'b0); pulse(1'b0); idle(6);
    chk("R1 gate closed", int'(countValue), 0);

    // sweep: window x mode/pin x density
    for (int g = 0; g < 4; g++) begin
      for (int c = 0; c < 4; c++) begin
        for (int d = 0; d < 3; d++) begin
          int dens;
          dens = (d == 0) ? 1 : (d == 1) ? 5 : 3;
          measure(g, c[1], c[0], dens);
        end
      end
    end

    // R5: unlimited window, direct mode, first input
    wr(2'd0, 8'h0C);
    wr(2'd1, 8'h03);
    chk("R5 busy at start", int'(busy), 1);
    for (int p = 0; p < 5; p++) pulse(1'b0);
    idle(6);
    chk("R5 counts without tick", int'(countValue), 5);
    for (int k = 0; k < 20; k++) begin
      tick();
      pulse(1'b0);
      idle(6);
    end
    chk("R5 still busy after ticks", int'(busy), 1);
    chk("R5 counting across ticks", int'(countValue), 25);
    wr(2'd0, 8'h00);
    chk("R5 finite write ends gate", int'(busy), 0);
    rd(2'd0, v);
    chk("R5 only window field changed", v, 8'h08);
    pulse(1'b0); idle(6);
    chk("R8 hold after unlimited", int'(countValue), 25);

    // R10: writes while busy ignored
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h02);
    tick();
    for (int p = 0; p < 4; p++) pulse(1'b0);
    idle(6);
    wr(2'd0, 8'h0B);
    wr(2'd1, 8'h02);
    rd(2'd0, v);
    chk("R10 mode write ignored", v, 8'h01);
    tick(); tick(); tick();
    chk("R10 length kept", int'(busy), 1);
    tick();
    chk("R10 ends after 4 ticks", int'(busy), 0);
    expv = 2;
    chk("R10 halved mode kept", int'(countValue), expv);

    // R2: clear on idle block
    wr(2'd1, 8'h01);
    chk("R2 clear idle", int'(countValue), 0);
    rd(2'd2, v);
    chk("R11 judge idle", v, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule